// File: doc/BRIEF.md
# Sequential Restoring Divider

This block divides a double-width dividend by a single-width divisor over several clock cycles and produces one quotient bit per cycle. The dividend comes in as two halves, an upper word and a lower word. The quotient and the remainder leave on separate result ports. A two-bit size select picks the operand width for each operation: 8 bits, 16 bits, or the full parameter width `W`. A mode input picks unsigned or two's-complement arithmetic for each operation.

An operation starts when `start` is high and the block is idle. While `busy` is high the block ignores further `start` pulses. At the end of an operation `done` pulses for one cycle and `div_err` shows whether the operation failed. The operation fails when the divisor is zero or when the quotient does not fit in the selected width. The sign rules give signed quotients a lower bound one larger in magnitude than the upper bound. A failed operation leaves the result ports as they were.

Top module: `seq_divider`

## Requirements
- R1: `size_sel` picks the operand width n: 0 gives 8, 1 gives 16, 2 and 3 give W. Only bits [n-1:0] of each operand input are used. Result bits above n-1 read zero.
- R2: The dividend is the 2n-bit value {dvd_hi[n-1:0], dvd_lo[n-1:0]}. The quotient appears on `quotient` and the remainder appears on `remainder`.
- R3: With `signed_mode` low, the quotient is floor(dividend/divisor) and the remainder is dividend mod divisor, both unsigned.
- R4: A divisor whose low n bits are all zero ends the operation with `div_err` high.
- R5: In unsigned mode, a quotient greater than 2^n-1 ends the operation with `div_err` high. This happens exactly when the upper dividend half is not below the divisor.
- R6: With `signed_mode` high, division truncates toward zero. The quotient is negative when the operand signs differ, and the remainder takes the sign of the dividend.
- R7: In signed mode, a true quotient in the range -2^(n-1) to 2^(n-1)-1 is valid. Anything outside it, including the most negative dividend divided by -1, sets `div_err`.
- R8: When `div_err` is reported, `quotient` and `remainder` keep the values they had before the operation.
- R9: A successful operation raises `done` exactly n cycles after the start edge in unsigned mode and n+2 cycles after it in signed mode.
- R10: `done` is a single-cycle pulse and `busy` is low while `done` is high. A `start` that arrives while `busy` is high is ignored and produces no result.
- R11: After reset, `busy`, `done`, `div_err`, `quotient` and `remainder` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation when idle |
| size_sel | input | 2 | Operand width select (0: 8, 1: 16, else W) |
| signed_mode | input | 1 | 1 selects two's-complement division |
| dvd_hi | input | W | Upper half of the dividend |
| dvd_lo | input | W | Lower half of the dividend |
| divisor | input | W | Divisor |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| quotient | output | W | Registered quotient, zero-extended |
| remainder | output | W | Registered remainder, zero-extended |
| div_err | output | 1 | Divide error for the operation that just completed |

## Verification
The bench targets the most negative dividend divided by -1 at the 16-bit and 32-bit widths, where a design without the asymmetric bound would return a wrapped quotient. It also targets quotients that sit exactly on the limits: -2^(n-1) must be accepted, +2^(n-1) must be rejected, and 2^n-1 must be accepted in unsigned mode. Getting the sign rules wrong would flip one of these outcomes. The bench drives nonzero junk in the unused upper operand bits, so a design that leaked those bits would produce wrong quotients. It also sends a `start` pulse during a long operation, which a design that did not ignore it would answer with a second result. After each divide error the bench checks that the result ports kept their previous values.

// File: rtl/seqdiv_pkg.sv
package seqdiv_pkg;

  // Controller states of the divider.
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PREP = 2'd1,
    ST_ITER = 2'd2,
    ST_FIX  = 2'd3
  } div_state_e;

  // size_sel encodings
  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;

endpackage

// File: rtl/seqdiv_prep.sv
// Operand conditioning: width masking, magnitude conversion, zero and
// early-overflow detection. Purely combinational.
module seqdiv_prep #(
  parameter int W  = 32,
  parameter int CW = $clog2(W + 1)
) (
  input  logic [CW-1:0] n,
  input  logic          is_signed,
  input  logic [W-1:0]  hi_in,
  input  logic [W-1:0]  lo_in,
  input  logic [W-1:0]  dv_in,
  output logic [W-1:0]  mag_hi,
  output logic [W-1:0]  mag_lo,
  output logic [W-1:0]  mag_dv,
  output logic          neg_dvd,
  output logic          neg_dv,
  output logic          dv_zero,
  output logic          early_ovf
);
  localparam int DW = 2 * W;

  logic [W:0]    one_n, lim_n;
  logic [W-1:0]  mask, sign_bit;
  logic [W-1:0]  hi_m, lo_m, dv_m, dv_sx;
  logic [DW:0]   one_d, lim_d;
  logic [DW-1:0] wide, wide_sx, wide_mag, wide_sh;

  always_comb begin
    one_n    = {{W{1'b0}}, 1'b1};
    lim_n    = (one_n << n) - one_n;
    mask     = lim_n[W-1:0];
    sign_bit = mask ^ (mask >> 1);

    hi_m = hi_in & mask;
    lo_m = lo_in & mask;
    dv_m = dv_in & mask;

    neg_dvd = is_signed && ((hi_m & sign_bit) != '0);
    neg_dv  = is_signed && ((dv_m & sign_bit) != '0);

    // 2n-bit dividend, sign-extended to 2W before negation
    one_d    = {{DW{1'b0}}, 1'b1};
    lim_d    = (one_d << {n, 1'b0}) - one_d;
    wide     = ({{W{1'b0}}, hi_m} << n) | {{W{1'b0}}, lo_m};
    wide_sx  = neg_dvd ? (wide | ~lim_d[DW-1:0]) : wide;
    wide_mag = neg_dvd ? (~wide_sx + {{(DW-1){1'b0}}, 1'b1}) : wide_sx;
    wide_sh  = wide_mag >> n;

    mag_lo = wide_mag[W-1:0] & mask;
    mag_hi = wide_sh[W-1:0] & mask;

    dv_sx  = neg_dv ? (dv_m | ~mask) : dv_m;
    mag_dv = (neg_dv ? (~dv_sx + {{(W-1){1'b0}}, 1'b1}) : dv_sx) & mask;

    dv_zero   = (dv_m == '0);
    early_ovf = (mag_hi >= mag_dv);
  end
endmodule

// File: rtl/seqdiv_step.sv
// One restoring iteration: shift the partial remainder left, pull in the
// next dividend bit, subtract when the divisor fits.
module seqdiv_step #(
  parameter int W = 32
) (
  input  logic [W-1:0] rem_in,
  input  logic [W-1:0] quo_in,
  input  logic [W-1:0] dv,
  output logic [W-1:0] rem_out,
  output logic [W-1:0] quo_out
);
  logic [W:0] trial, diff;
  logic       take;

  always_comb begin
    // The extra top bit keeps the bit shifted out of the remainder.
    trial   = {rem_in, quo_in[W-1]};
    take    = (trial >= {1'b0, dv});
    diff    = trial - {1'b0, dv};
    rem_out = take ? diff[W-1:0] : trial[W-1:0];
    quo_out = {quo_in[W-2:0], take};
  end
endmodule

// File: rtl/seqdiv_fix.sv
// Signed result correction and representability check.
module seqdiv_fix #(
  parameter int W  = 32,
  parameter int CW = $clog2(W + 1)
) (
  input  logic [CW-1:0] n,
  input  logic          is_signed,
  input  logic          neg_dvd,
  input  logic          neg_dv,
  input  logic [W-1:0]  q_mag,
  input  logic [W-1:0]  r_mag,
  output logic [W-1:0]  q_out,
  output logic [W-1:0]  r_out,
  output logic          ovf
);
  logic [W:0]   one_n, lim_n;
  logic [W-1:0] mask, half;
  logic         differ;

  always_comb begin
    one_n  = {{W{1'b0}}, 1'b1};
    lim_n  = (one_n << n) - one_n;
    mask   = lim_n[W-1:0];
    half   = mask ^ (mask >> 1);
    differ = neg_dvd ^ neg_dv;

    if (!is_signed) begin
      ovf   = 1'b0;
      q_out = q_mag;
      r_out = r_mag;
    end else begin
      ovf   = differ ? (q_mag > half) : (q_mag >= half);
      q_out = differ  ? ((~q_mag + {{(W-1){1'b0}}, 1'b1}) & mask) : q_mag;
      r_out = neg_dvd ? ((~r_mag + {{(W-1){1'b0}}, 1'b1}) & mask) : r_mag;
    end
  end
endmodule

// File: rtl/seq_divider.sv
module seq_divider
  import seqdiv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [1:0]   size_sel,
  input  logic         signed_mode,
  input  logic [W-1:0] dvd_hi,
  input  logic [W-1:0] dvd_lo,
  input  logic [W-1:0] divisor,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] quotient,
  output logic [W-1:0] remainder,
  output logic         div_err
);
  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] N_BYTE = CW'(8);
  localparam logic [CW-1:0] N_HALF = CW'(16);
  localparam logic [CW-1:0] N_FULL = CW'(W);

  div_state_e    state;
  logic [CW-1:0] cnt, n_q, n_req, n_use, align;
  logic [W-1:0]  hi_raw, lo_raw, dv_raw;
  logic [W-1:0]  rem_q, quo_q, dv_q;
  logic [W-1:0]  q_o, r_o;
  logic          sgn_q, neg_dvd_q, neg_dv_q, done_o, err_o;

  logic          in_idle, launch, p_sgn;
  logic [W-1:0]  p_hi, p_lo, p_dv, p_mhi, p_mlo, p_mdv;
  logic          p_na, p_nb, p_zero, p_early;
  logic [W-1:0]  s_rem, s_quo, f_q, f_r;
  logic          f_ovf;

  always_comb begin
    case (size_sel)
      SZ_BYTE: n_req = N_BYTE;
      SZ_HALF: n_req = N_HALF;
      default: n_req = N_FULL;
    endcase
    in_idle = (state == ST_IDLE);
    p_hi    = in_idle ? dvd_hi      : hi_raw;
    p_lo    = in_idle ? dvd_lo      : lo_raw;
    p_dv    = in_idle ? divisor     : dv_raw;
    p_sgn   = in_idle ? signed_mode : sgn_q;
    n_use   = in_idle ? n_req       : n_q;
    align   = N_FULL - n_use;
    launch  = (in_idle && start && !signed_mode) || (state == ST_PREP);
  end

  seqdiv_prep #(.W(W), .CW(CW)) u_prep (
    .n         (n_use),
    .is_signed (p_sgn),
    .hi_in     (p_hi),
    .lo_in     (p_lo),
    .dv_in     (p_dv),
    .mag_hi    (p_mhi),
    .mag_lo    (p_mlo),
    .mag_dv    (p_mdv),
    .neg_dvd   (p_na),
    .neg_dv    (p_nb),
    .dv_zero   (p_zero),
    .early_ovf (p_early)
  );

  seqdiv_step #(.W(W)) u_step (
    .rem_in  (rem_q),
    .quo_in  (quo_q),
    .dv      (dv_q),
    .rem_out (s_rem),
    .quo_out (s_quo)
  );

  seqdiv_fix #(.W(W), .CW(CW)) u_fix (
    .n         (n_q),
    .is_signed (sgn_q),
    .neg_dvd   (neg_dvd_q),
    .neg_dv    (neg_dv_q),
    .q_mag     (quo_q),
    .r_mag     (rem_q),
    .q_out     (f_q),
    .r_out     (f_r),
    .ovf       (f_ovf)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      n_q       <= '0;
      hi_raw    <= '0;
      lo_raw    <= '0;
      dv_raw    <= '0;
      sgn_q     <= 1'b0;
      neg_dvd_q <= 1'b0;
      neg_dv_q  <= 1'b0;
      rem_q     <= '0;
      quo_q     <= '0;
      dv_q      <= '0;
      q_o       <= '0;
      r_o       <= '0;
      err_o     <= 1'b0;
      done_o    <= 1'b0;
    end else begin
      done_o <= 1'b0;

      if (in_idle && start) begin
        hi_raw <= dvd_hi;
        lo_raw <= dvd_lo;
        dv_raw <= divisor;
        n_q    <= n_req;
        sgn_q  <= signed_mode;
        if (signed_mode) state <= ST_PREP;
      end

      if (launch) begin
        if (p_zero || p_early) begin
          err_o  <= 1'b1;
          done_o <= 1'b1;
          state  <= ST_IDLE;
        end else begin
          rem_q     <= p_mhi;
          quo_q     <= p_mlo << align;
          dv_q      <= p_mdv;
          neg_dvd_q <= p_na;
          neg_dv_q  <= p_nb;
          cnt       <= n_use;
          state     <= ST_ITER;
        end
      end

      if (state == ST_ITER) begin
        rem_q <= s_rem;
        quo_q <= s_quo;
        cnt   <= cnt - CW'(1);
        if (cnt == CW'(1)) begin
          if (sgn_q) begin
            state <= ST_FIX;
          end else begin
            q_o    <= s_quo;
            r_o    <= s_rem;
            err_o  <= 1'b0;
            done_o <= 1'b1;
            state  <= ST_IDLE;
          end
        end
      end

      if (state == ST_FIX) begin
        state  <= ST_IDLE;
        done_o <= 1'b1;
        if (f_ovf) begin
          err_o <= 1'b1;
        end else begin
          err_o <= 1'b0;
          q_o   <= f_q;
          r_o   <= f_r;
        end
      end
    end
  end

  assign busy      = (state != ST_IDLE);
  assign done      = done_o;
  assign quotient  = q_o;
  assign remainder = r_o;
  assign div_err   = err_o;

endmodule

// File: rtl/seqdiv_checker.sv
module seqdiv_checker #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         start,
  input logic [1:0]   size_sel,
  input logic         signed_mode,
  input logic [W-1:0] divisor,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] quotient,
  input logic [W-1:0] remainder,
  input logic         div_err
);
  localparam int LW = $clog2(W + 3) + 1;

  logic [LW-1:0] elapsed, exp_lat;
  logic          zero_op;
  logic [W-1:0]  dv_low;
  logic [LW-1:0] n_acc;

  always_comb begin
    case (size_sel)
      2'd0:    n_acc = LW'(8);
      2'd1:    n_acc = LW'(16);
      default: n_acc = LW'(W);
    endcase
    case (size_sel)
      2'd0:    dv_low = divisor & W'(8'hFF);
      2'd1:    dv_low = divisor & W'(16'hFFFF);
      default: dv_low = divisor;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      elapsed <= '0;
      exp_lat <= '0;
      zero_op <= 1'b0;
    end else if (start && !busy) begin
      elapsed <= '0;
      exp_lat <= n_acc + (signed_mode ? LW'(2) : LW'(0));
      zero_op <= (dv_low == '0);
    end else if (busy) begin
      elapsed <= elapsed + LW'(1);
    end
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done && !start |=> !done); // R10

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
    busy |-> !done); // R10

  AST_ERR_KEEPS_RESULT: assert property (@(posedge clk) disable iff (rst)
    done && div_err |-> $stable(quotient) && $stable(remainder)); // R8

  AST_ZERO_DIVISOR: assert property (@(posedge clk) disable iff (rst)
    done && zero_op |-> div_err); // R4

  AST_LATENCY: assert property (@(posedge clk) disable iff (rst)
    done && !div_err |-> elapsed == exp_lat); // R9

endmodule

bind seq_divider seqdiv_checker #(.W(W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .start       (start),
  .size_sel    (size_sel),
  .signed_mode (signed_mode),
  .divisor     (divisor),
  .busy        (busy),
  .done        (done),
  .quotient    (quotient),
  .remainder   (remainder),
  .div_err     (div_err)
);

// File: tb/tb_seq_divider.sv
module tb_seq_divider;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [1:0]   size_sel = 2'd0;
  logic         signed_mode = 1'b0;
  logic [W-1:0] dvd_hi = '0, dvd_lo = '0, divisor = '0;
  logic         busy, done, div_err;
  logic [W-1:0] quotient, remainder;

  seq_divider #(.W(W)) dut (
    .clk(clk), .rst(rst), .start(start), .size_sel(size_sel),
    .signed_mode(signed_mode), .dvd_hi(dvd_hi), .dvd_lo(dvd_lo),
    .divisor(divisor), .busy(busy), .done(done), .quotient(quotient),
    .remainder(remainder), .div_err(div_err)
  );

  always #10 clk = ~clk;

  typedef struct {
    logic [W-1:0] q;
    logic [W-1:0] r;
    logic         err;
    int           lat;
    int           t0;
    string        tag;
  } exp_t;

  exp_t         sb[$];
  int           cyc = 0;
  int           tests = 0, fails = 0;
  int           pushed = 0, popped = 0;
  logic [W-1:0] last_q = '0, last_r = '0;
  bit           ended = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic report();
    if (!ended) begin
      ended = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  // Monitor: pop expected items as results appear.
  always @(negedge clk) begin
    if (!rst && done) begin
      tests++;
      if (busy) begin
        fails++;
        $display("FAIL R10 busy high with done: actual=1 expected=0");
      end
      if (sb.size() == 0) begin
        fails++;
        $display("FAIL R10 unexpected done: actual=done expected=none");
      end else begin
        exp_t e;
        int   lat;
        e   = sb.pop_front();
        lat = cyc - e.t0 - 1;
        if (quotient !== e.q || remainder !== e.r || div_err !== e.err ||
            (!e.err && lat != e.lat)) begin
          fails++;
          $display("FAIL %s: actual q=%h r=%h err=%b lat=%0d expected q=%h r=%h err=%b lat=%0d",
                   e.tag, quotient, remainder, div_err, lat, e.q, e.r, e.err, e.lat);
        end
        popped++;
      end
    end
  end

  // Driver: compute expected result from the requirements, then launch.
  task automatic run_op(input string tag, input logic [1:0] sel, input logic sgn,
                        input logic [W-1:0] hi, input logic [W-1:0] lo,
                        input logic [W-1:0] dv);
    int           n;
    logic [127:0] mk, hm, lm, dm, dvd, a, b, qm, rm, half;
    logic         na, nb, err;
    exp_t         e;
    n    = (sel == 2'd0) ? 8 : (sel == 2'd1) ? 16 : W;
    mk   = (128'd1 << n) - 128'd1;
    half = 128'd1 << (n - 1);
    hm   = {96'd0, hi} & mk;
    lm   = {96'd0, lo} & mk;
    dm   = {96'd0, dv} & mk;
    dvd  = (hm << n) | lm;
    na   = sgn && dvd[2*n-1];
    nb   = sgn && dm[n-1];
    a    = na ? ((128'd1 << (2*n)) - dvd) : dvd;
    b    = nb ? ((128'd1 << n) - dm) : dm;
    qm   = '0;
    rm   = '0;
    if (b == 0) err = 1'b1;
    else begin
      qm = a / b;
      rm = a % b;
      if (!sgn)         err = (qm > mk);
      else if (na ^ nb) err = (qm > half);
      else              err = (qm >= half);
    end
    e.err = err;
    e.tag = tag;
    e.lat = sgn ? n + 2 : n;
    if (err) begin
      e.q = last_q;
      e.r = last_r;
    end else begin
      logic [127:0] qf, rf;
      qf = (na ^ nb) ? (((128'd1 << n) - qm) & mk) : qm;
      rf = na ? (((128'd1 << n) - rm) & mk) : rm;
      e.q = qf[W-1:0];
      e.r = rf[W-1:0];
      last_q = e.q;
      last_r = e.r;
    end
    @(negedge clk);
    size_sel    = sel;
    signed_mode = sgn;
    dvd_hi      = hi;
    dvd_lo      = lo;
    divisor     = dv;
    start       = 1'b1;
    e.t0        = cyc;
    sb.push_back(e);
    pushed++;
    @(negedge clk);
    start = 1'b0;
    while (popped < pushed) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL R10 watchdog: actual=hung expected=done");
    report();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R11 reset state
    tests++;
    if (busy !== 1'b0 || done !== 1'b0 || div_err !== 1'b0 ||
        quotient !== '0 || remainder !== '0) begin
      fails++;
      $display("FAIL R11 reset: actual busy=%b done=%b err=%b q=%h r=%h expected all 0",
               busy, done, div_err, quotient, remainder);
    end

    // R3 R2 unsigned basics, upper junk bits (R1)
    run_op("R3 u8 basic",     2'd0, 1'b0, 32'hDEAD_0012, 32'hBEEF_0034, 32'h1234_0056);
    run_op("R1 u16 junk",     2'd1, 1'b0, 32'hFFFF_0123, 32'hAAAA_4567, 32'h5555_89AB);
    run_op("R2 u32 basic",    2'd2, 1'b0, 32'h0000_0001, 32'h0000_0000, 32'h0000_0002);
    run_op("R3 u32 max q",    2'd3, 1'b0, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 32'h8000_0000);
    run_op("R3 u8 max q",     2'd0, 1'b0, 32'h0000_007F, 32'h0000_00FF, 32'h0000_0080);
    // R4 zero divisor, including nonzero junk above bit 7
    run_op("R4 zero u8",      2'd0, 1'b0, 32'h0, 32'h10, 32'hFFFF_FF00);
    run_op("R4 zero s32",     2'd2, 1'b1, 32'h0, 32'h10, 32'h0);
    // R5 unsigned overflow, upper equals divisor
    run_op("R5 ovf u8",       2'd0, 1'b0, 32'h55, 32'h00, 32'h55);
    run_op("R5 ovf u16",      2'd1, 1'b0, 32'hFFFF, 32'h0, 32'h1);
    // R6 signed sign rules
    run_op("R6 s8 -7/2",      2'd0, 1'b1, 32'hFF, 32'hF9, 32'h02);
    run_op("R6 s8 7/-2",      2'd0, 1'b1, 32'h00, 32'h07, 32'hFE);
    run_op("R6 s16 -100/-7",  2'd1, 1'b1, 32'hFFFF, 32'hFF9C, 32'hFFF9);
    // R7 signed bounds
    run_op("R7 s8 -128/1",    2'd0, 1'b1, 32'hFF, 32'h80, 32'h01);
    run_op("R7 s8 128/-1",    2'd0, 1'b1, 32'h00, 32'h80, 32'hFF);
    run_op("R7 s8 128/1",     2'd0, 1'b1, 32'h00, 32'h80, 32'h01);
    run_op("R7 s16 min/-1",   2'd1, 1'b1, 32'h8000, 32'h0000, 32'hFFFF);
    run_op("R7 s32 min/-1",   2'd2, 1'b1, 32'h8000_0000, 32'h0, 32'hFFFF_FFFF);
    run_op("R7 s32 -2^31/1",  2'd2, 1'b1, 32'hFFFF_FFFF, 32'h8000_0000, 32'h1);
    run_op("R8 after ovf",    2'd2, 1'b1, 32'h0, 32'h8000_0000, 32'h1);

    // R10 start while busy must be ignored
    begin
      exp_t e;
      @(negedge clk);
      size_sel = 2'd2; signed_mode = 1'b1;
      dvd_hi = 32'h0000_0003; dvd_lo = 32'h1234_5678; divisor = 32'h0000_0100;
      start = 1'b1;
      e.t0 = cyc; e.lat = W + 2; e.err = 1'b0; e.tag = "R10 busy ignore";
      e.q = 32'h0312_3456; e.r = 32'h0000_0078;
      last_q = e.q; last_r = e.r;
      sb.push_back(e); pushed++;
      @(negedge clk);
      start = 1'b0;
      repeat (3) @(negedge clk);
      dvd_hi = 32'h0; dvd_lo = 32'h5; divisor = 32'h0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (popped < pushed) @(negedge clk);
      repeat (W + 4) @(negedge clk);
    end

    // R3 R6 mixed operations
    for (int i = 0; i < 80; i++) begin
      logic [1:0]  s;
      logic        m;
      logic [31:0] h;
      s = 2'($urandom % 4);
      m = 1'($urandom % 2);
      h = $urandom >> ($urandom % 32);
      run_op(m ? "R6 mixed" : "R3 mixed", s, m, h, $urandom, $urandom);
    end

    repeat (3) @(negedge clk);
    report();
  end
endmodule